// File: doc/BRIEF.md
# Unaligned Store Stream Coalescer

This block sits between a vector unit and a block-organised scratch memory. It takes a stream of full-width vector stores whose byte address need not be block aligned. It cuts each store into aligned block writes with byte strobes. Any bytes that spill past the last complete block are held in a residual buffer. They join the first block of the next store in the stream, or they are written when the stream is closed.

A stream opens with the first store after reset or after a flush. That store supplies the start address. Later stores continue at an internal write cursor, which always moves on by one vector. A separate logical position counts from zero at stream open and grows by one vector only for stores that request post-update. The stream ends with a flush command that carries a byte offset:
- If the offset equals the logical position, any residual bytes are written with their strobes.
- If it does not, the residual is thrown away and an error is flagged.

In both cases the stream state is consumed.

Top module: `ustore_coalescer`

## Requirements
- R1: After reset, `wr_valid`, `fl_done` and `fl_err` are low, and `st_ready` and `fl_ready` are high.
- R2: An accepted store produces exactly VEC_BYTES/BLK_BYTES block writes, one per cycle, in the cycles 1 to VEC_BYTES/BLK_BYTES after the accepting edge. Their addresses start at the store's cursor rounded down to a multiple of BLK_BYTES and rise by BLK_BYTES each beat.
- R3: Byte j of `st_data` (bits 8j+7:8j) goes to byte address cursor+j, that is, to lane (address mod BLK_BYTES) of the block write covering it, with its strobe bit set. Lanes holding no stream byte have strobe 0 and data 0, and every write carries at least one strobe.
- R4: `st_ready` is low during the cycles in which a store's block writes are presented. A store held valid over that time is accepted at the first edge after `st_ready` returns, which is VEC_BYTES/BLK_BYTES+1 edges after the previous acceptance.
- R5: The trailing cursor mod BLK_BYTES bytes of a store produce no memory write when the store is made. No write appears at any time other than those given in R2 and R8.
- R6: In an open stream, the residual bytes are merged into the low lanes of the first block write of the next store, next to that store's own bytes.
- R7: With `st_post`=1, a store adds VEC_BYTES to the logical position. With `st_post`=0, it leaves the position unchanged. The position is 0 when a stream opens.
- R8: A flush whose `fl_off` (in bytes) equals the position, with a non-empty residual, produces one write in the cycle after acceptance. The write goes to the residual's aligned block and carries only the residual strobes. `fl_done` pulses high for that one cycle with `fl_err` low.
- R9: A flush whose offset differs from the position makes no write and pulses `fl_done` and `fl_err` together for one cycle. The residual is discarded, so the next stream's first block carries none of it.
- R10: A matching flush with an empty residual pulses `fl_done` without any write.
- R11: `st_addr` is used only by the store that opens a stream, and is ignored by later stores in the same stream.
- R12: `fl_ready` is low while `st_valid` is high or while writes are pending, so a flush never overtakes a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store command valid |
| st_ready | output | 1 | Store command accepted when high with st_valid |
| st_addr | input | ADDR_W | Start byte address, used by a stream-opening store |
| st_post | input | 1 | 1: advance logical position by one vector |
| st_data | input | VEC_BYTES*8 | Vector payload, byte j in bits 8j+7:8j |
| fl_valid | input | 1 | Flush command valid |
| fl_ready | output | 1 | Flush command accepted when high with fl_valid |
| fl_off | input | ADDR_W | Flush byte offset, compared with the logical position |
| wr_valid | output | 1 | Block write valid |
| wr_addr | output | ADDR_W | Block-aligned byte address |
| wr_data | output | BLK_BYTES*8 | Block data, lane i in bits 8i+7:8i |
| wr_strb | output | BLK_BYTES | Byte strobes, one per lane |
| fl_done | output | 1 | One-cycle pulse when a flush completes |
| fl_err | output | 1 | One-cycle pulse with fl_done on an offset mismatch |

## Verification
For every write, the bench works out the cycle in which the write is due. Store beat k is due k cycles after the accepting edge, and a flush's tail write and its done and error pulses are due one cycle after their accepting edge. When it drives a command, the driver notes the accepting edge from a free-running cycle count. It then places each expected write, with its address, strobes, data and due cycle, into the scoreboard queue. The monitor samples on the falling edge and pops one entry per presented write. It flags any write that comes early, comes late, is missing or is unexpected. The flush pulses are checked directly on their due cycle and again one cycle later, to confirm they last a single cycle.

// File: rtl/usc_pkg.sv
package usc_pkg;

    localparam int DEF_VEC_BYTES = 256;
    localparam int DEF_BLK_BYTES = 32;
    localparam int DEF_ADDR_W    = 16;

    // Outcome of a flush command, chosen at acceptance.
    typedef enum logic [1:0] {
        FL_IDLE       = 2'd0,
        FL_WRITE_TAIL = 2'd1,
        FL_EMPTY_OK   = 2'd2,
        FL_MISMATCH   = 2'd3
    } flush_kind_e;

    typedef struct packed {
        logic done;
        logic err;
    } flush_evt_t;

    function automatic flush_kind_e classify_flush(input logic hit, input logic has_tail);
        if (!hit)
            return FL_MISMATCH;
        else if (has_tail)
            return FL_WRITE_TAIL;
        else
            return FL_EMPTY_OK;
    endfunction

endpackage

// File: rtl/usc_merge.sv
// Places an incoming vector at its lane offset and folds in the residual
// bytes that precede it in the same aligned block.
module usc_merge #(
    parameter int VB = 256,
    parameter int BB = 32
) (
    input  logic [VB*8-1:0]       vec,
    input  logic [$clog2(BB)-1:0] ofs,
    input  logic [BB*8-1:0]       tail_d,
    input  logic [BB-1:0]         tail_s,
    output logic [(VB+BB)*8-1:0]  mrg_d,
    output logic [VB+BB-1:0]      mrg_s
);
    localparam int SB = VB + BB;

    logic [SB*8-1:0] sh_d;
    logic [SB-1:0]   sh_s;

    always_comb begin
        sh_d = {{(BB*8){1'b0}}, vec} << {ofs, 3'b000};
        sh_s = {{BB{1'b0}}, {VB{1'b1}}} << ofs;
    end

    generate
        for (genvar i = 0; i < SB; i++) begin : g_byte
            if (i < BB) begin : g_low
                assign mrg_d[i*8 +: 8] = sh_d[i*8 +: 8] | (tail_s[i] ? tail_d[i*8 +: 8] : 8'h00);
                assign mrg_s[i]        = sh_s[i] | tail_s[i];
            end else begin : g_high
                assign mrg_d[i*8 +: 8] = sh_d[i*8 +: 8];
                assign mrg_s[i]        = sh_s[i];
            end
        end
    endgenerate

endmodule

// File: rtl/usc_stage.sv
// Holds one merged store (VB/BB blocks plus one residual block). Each beat
// shifts one block out of the low end; what remains in the low block after
// the last beat is the residual tail.
module usc_stage #(
    parameter int VB = 256,
    parameter int BB = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld,
    input  logic [(VB+BB)*8-1:0]  ld_d,
    input  logic [VB+BB-1:0]      ld_s,
    input  logic                  adv,
    input  logic                  drop,
    output logic [BB*8-1:0]       out_d,
    output logic [BB-1:0]         out_s
);
    localparam int SB = VB + BB;

    logic [SB*8-1:0] st_d;
    logic [SB-1:0]   st_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_d <= '0;
            st_s <= '0;
        end else if (ld) begin
            st_d <= ld_d;
            st_s <= ld_s;
        end else if (drop) begin
            st_s <= '0;
        end else if (adv) begin
            st_d <= st_d >> (BB*8);
            st_s <= st_s >> BB;
        end
    end

    assign out_d = st_d[BB*8-1:0];
    assign out_s = st_s[BB-1:0];

endmodule

// File: rtl/usc_ctrl.sv
// Stream state: open flag, write cursor, logical position, beat counter.
module usc_ctrl
    import usc_pkg::*;
#(
    parameter int VB = 256,
    parameter int BB = 32,
    parameter int AW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    input  logic [AW-1:0]         st_addr,
    input  logic                  st_post,
    input  logic                  fl_valid,
    input  logic [AW-1:0]         fl_off,
    input  logic                  tail_any,
    output logic                  st_ready,
    output logic                  fl_ready,
    output logic [$clog2(BB)-1:0] ofs,
    output logic                  ld,
    output logic                  adv,
    output logic                  drop,
    output logic                  wr_valid,
    output logic [AW-1:0]         wr_addr,
    output flush_evt_t            evt
);
    localparam int NB   = VB / BB;
    localparam int BO_W = $clog2(BB);
    localparam int CW   = $clog2(NB + 1);
    localparam logic [AW-1:0] VB_A = AW'(VB);
    localparam logic [AW-1:0] BB_A = AW'(BB);

    logic          strm_open;
    logic [AW-1:0] cursor;
    logic [AW-1:0] pos;
    logic [AW-1:0] blk_addr;
    logic [CW-1:0] beats;

    logic          busy;
    logic          st_go;
    logic          fl_go;
    logic [AW-1:0] cur_eff;
    flush_kind_e   fl_kind;

    always_comb begin
        busy     = (beats != '0);
        st_ready = !busy;
        fl_ready = !busy && !st_valid;
        st_go    = st_valid && st_ready;
        fl_go    = fl_valid && fl_ready;
        cur_eff  = strm_open ? cursor : st_addr;
        ofs      = cur_eff[BO_W-1:0];
        fl_kind  = classify_flush(fl_off == pos, tail_any);
        ld       = st_go;
        adv      = busy;
        drop     = fl_go && (fl_kind == FL_MISMATCH);
        wr_valid = busy;
        wr_addr  = blk_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strm_open <= 1'b0;
            cursor    <= '0;
            pos       <= '0;
            blk_addr  <= '0;
            beats     <= '0;
            evt       <= '0;
        end else begin
            evt <= '0;
            if (st_go) begin
                cursor    <= cur_eff + VB_A;
                blk_addr  <= {cur_eff[AW-1:BO_W], {BO_W{1'b0}}};
                beats     <= CW'(NB);
                pos       <= (strm_open ? pos : '0) + (st_post ? VB_A : '0);
                strm_open <= 1'b1;
            end else if (fl_go) begin
                strm_open <= 1'b0;
                pos       <= '0;
                evt.done  <= 1'b1;
                evt.err   <= (fl_kind == FL_MISMATCH);
                if (fl_kind == FL_WRITE_TAIL)
                    beats <= CW'(1);
            end else if (busy) begin
                beats    <= beats - CW'(1);
                blk_addr <= blk_addr + BB_A;
            end
        end
    end

    // R7: a store without post-update keeps the position of an open stream
    a_r7_nopost_hold: assert property (@(posedge clk) disable iff (rst)
        (st_go && !st_post && strm_open) |=> (pos == $past(pos)));

    // R10: a matching flush with nothing buffered issues no write
    a_r10_empty_silent: assert property (@(posedge clk) disable iff (rst)
        (fl_go && !tail_any && (fl_off == pos)) |=> !wr_valid);

    // R2: every write goes to an aligned block
    a_r2_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[BO_W-1:0] == '0));

    // R9: a closed, idle stream holds no residual bytes
    a_r9_closed_empty: assert property (@(posedge clk) disable iff (rst)
        (!strm_open && !busy) |-> !tail_any);

endmodule

// File: rtl/ustore_coalescer.sv
module ustore_coalescer
    import usc_pkg::*;
#(
    parameter int VEC_BYTES = DEF_VEC_BYTES,
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    parameter int ADDR_W    = DEF_ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic                   st_post,
    input  logic [VEC_BYTES*8-1:0] st_data,
    input  logic                   fl_valid,
    output logic                   fl_ready,
    input  logic [ADDR_W-1:0]      fl_off,
    output logic                   wr_valid,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [BLK_BYTES*8-1:0] wr_data,
    output logic [BLK_BYTES-1:0]   wr_strb,
    output logic                   fl_done,
    output logic                   fl_err
);
    localparam int SB   = VEC_BYTES + BLK_BYTES;
    localparam int BO_W = $clog2(BLK_BYTES);

    logic [BO_W-1:0]        ofs;
    logic                   ld;
    logic                   adv;
    logic                   drop;
    logic [SB*8-1:0]        mrg_d;
    logic [SB-1:0]          mrg_s;
    logic [BLK_BYTES*8-1:0] low_d;
    logic [BLK_BYTES-1:0]   low_s;
    flush_evt_t             evt;

    usc_ctrl #(.VB(VEC_BYTES), .BB(BLK_BYTES), .AW(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_post  (st_post),
        .fl_valid (fl_valid),
        .fl_off   (fl_off),
        .tail_any (|low_s),
        .st_ready (st_ready),
        .fl_ready (fl_ready),
        .ofs      (ofs),
        .ld       (ld),
        .adv      (adv),
        .drop     (drop),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .evt      (evt)
    );

    usc_merge #(.VB(VEC_BYTES), .BB(BLK_BYTES)) u_merge (
        .vec    (st_data),
        .ofs    (ofs),
        .tail_d (low_d),
        .tail_s (low_s),
        .mrg_d  (mrg_d),
        .mrg_s  (mrg_s)
    );

    usc_stage #(.VB(VEC_BYTES), .BB(BLK_BYTES)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .ld    (ld),
        .ld_d  (mrg_d),
        .ld_s  (mrg_s),
        .adv   (adv),
        .drop  (drop),
        .out_d (low_d),
        .out_s (low_s)
    );

    generate
        for (genvar i = 0; i < BLK_BYTES; i++) begin : g_lane
            assign wr_data[i*8 +: 8] = low_s[i] ? low_d[i*8 +: 8] : 8'h00;
        end
    endgenerate

    assign wr_strb = low_s;
    assign fl_done = evt.done;
    assign fl_err  = evt.err;

    // R3: a presented block always carries at least one stream byte
    a_r3_strb_nonzero: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (|wr_strb));

    // R8: an error pulse never comes without the completion pulse
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        fl_err |-> fl_done);

    // R12: a flush completion never coincides with a pending store beat start
    a_r12_flush_order: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready) |=> !fl_done);

endmodule

// File: tb/ustore_coalescer_tb.sv
`timescale 1ns/1ps
module ustore_coalescer_tb;
    localparam int VB = 256;
    localparam int BB = 32;
    localparam int AW = 16;
    localparam int NB = VB / BB;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            st_valid = 1'b0;
    logic            st_ready;
    logic [AW-1:0]   st_addr = '0;
    logic            st_post = 1'b0;
    logic [VB*8-1:0] st_data = '0;
    logic            fl_valid = 1'b0;
    logic            fl_ready;
    logic [AW-1:0]   fl_off = '0;
    logic            wr_valid;
    logic [AW-1:0]   wr_addr;
    logic [BB*8-1:0] wr_data;
    logic [BB-1:0]   wr_strb;
    logic            fl_done;
    logic            fl_err;

    ustore_coalescer #(.VEC_BYTES(VB), .BLK_BYTES(BB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_post(st_post), .st_data(st_data),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_off(fl_off),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .fl_done(fl_done), .fl_err(fl_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // scoreboard queues
    logic [AW-1:0]   q_addr[$];
    logic [BB*8-1:0] q_data[$];
    logic [BB-1:0]   q_strb[$];
    int              q_cyc[$];
    string           q_tag[$];

    // reference model of the stream
    logic [7:0] m_res[BB];
    bit         m_rv[BB];
    int         m_cur = 0;
    int         m_pos = 0;
    bit         m_open = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] vbyte(input int seed, input int j);
        return 8'((seed * 37) + (j * 13) + 1);
    endfunction

    // monitor: one scoreboard entry per presented write
    logic [AW-1:0]   e_a;
    logic [BB*8-1:0] e_d;
    logic [BB-1:0]   e_s;
    int              e_c;
    string           e_t;
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (q_addr.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R5 unexpected write actual=%0h expected=none", wr_addr);
            end else begin
                e_a = q_addr.pop_front();
                e_d = q_data.pop_front();
                e_s = q_strb.pop_front();
                e_c = q_cyc.pop_front();
                e_t = q_tag.pop_front();
                chk(wr_addr == e_a, e_t, "write addr", wr_addr, e_a);
                chk(wr_strb == e_s, e_t, "write strb", wr_strb, e_s);
                chk(wr_data == e_d, e_t, "write data", wr_data[63:0], e_d[63:0]);
                chk(cyc == e_c, e_t, "write cycle", cyc, e_c);
            end
        end
    end

    task automatic do_store(input int addr, input bit post, input int seed,
                            input string tag, input bit chk_fl, output int acc);
        int cur;
        int a;
        int base;
        logic [VB*8-1:0] d;
        for (int j = 0; j < VB; j++) d[j*8 +: 8] = vbyte(seed, j);
        st_valid = 1'b1;
        st_addr  = AW'(addr);
        st_post  = post;
        st_data  = d;
        if (chk_fl) begin
            #1;
            // R12: a pending store blocks the flush
            chk(fl_ready == 1'b0, "R12", "fl_ready with store pending", fl_ready, 0);
        end
        while (!st_ready) @(negedge clk);
        acc  = cyc + 1;
        cur  = m_open ? m_cur : addr;
        a    = cur % BB;
        base = cur - a;
        for (int b = 0; b < NB; b++) begin
            logic [BB*8-1:0] xd;
            logic [BB-1:0]   xs;
            for (int i = 0; i < BB; i++) begin
                int x;
                x = base + b * BB + i;
                if (x >= cur && x < cur + VB) begin
                    xd[i*8 +: 8] = d[(x - cur)*8 +: 8];
                    xs[i] = 1'b1;
                end else if (b == 0 && i < a && m_rv[i]) begin
                    xd[i*8 +: 8] = m_res[i];
                    xs[i] = 1'b1;
                end else begin
                    xd[i*8 +: 8] = 8'h00;
                    xs[i] = 1'b0;
                end
            end
            q_addr.push_back(AW'(base + b * BB));
            q_data.push_back(xd);
            q_strb.push_back(xs);
            q_cyc.push_back(acc + b);
            q_tag.push_back(tag);
        end
        for (int i = 0; i < BB; i++) begin
            if (i < a) begin
                m_res[i] = d[(VB + i - a)*8 +: 8];
                m_rv[i]  = 1'b1;
            end else begin
                m_res[i] = 8'h00;
                m_rv[i]  = 1'b0;
            end
        end
        m_pos  = (m_open ? m_pos : 0) + (post ? VB : 0);
        m_cur  = cur + VB;
        m_open = 1;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_flush(input int off, input string tag);
        bit hit;
        bit any;
        int acc;
        fl_valid = 1'b1;
        fl_off   = AW'(off);
        while (!fl_ready) @(negedge clk);
        acc = cyc + 1;
        hit = (off == (m_open ? m_pos : 0));
        any = 0;
        for (int i = 0; i < BB; i++) any |= m_rv[i];
        if (hit && any) begin
            logic [BB*8-1:0] xd;
            logic [BB-1:0]   xs;
            for (int i = 0; i < BB; i++) begin
                xd[i*8 +: 8] = m_rv[i] ? m_res[i] : 8'h00;
                xs[i] = m_rv[i];
            end
            q_addr.push_back(AW'(m_cur - (m_cur % BB)));
            q_data.push_back(xd);
            q_strb.push_back(xs);
            q_cyc.push_back(acc);
            q_tag.push_back(tag);
        end
        for (int i = 0; i < BB; i++) m_rv[i] = 1'b0;
        m_open = 0;
        m_pos  = 0;
        @(posedge clk);
        @(negedge clk);
        fl_valid = 1'b0;
        chk(fl_done == 1'b1, tag, "fl_done pulse", fl_done, 1);
        chk(fl_err == !hit, tag, "fl_err pulse", fl_err, !hit);
        @(negedge clk);
        chk(fl_done == 1'b0, tag, "fl_done one cycle", fl_done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int acc1;
        int acc2;
        for (int i = 0; i < BB; i++) begin
            m_res[i] = 8'h00;
            m_rv[i]  = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: idle state after reset
        chk(wr_valid == 1'b0, "R1", "wr_valid", wr_valid, 0);
        chk(st_ready == 1'b1, "R1", "st_ready", st_ready, 1);
        chk(fl_ready == 1'b1, "R1", "fl_ready", fl_ready, 1);
        chk(fl_done == 1'b0 && fl_err == 1'b0, "R1", "flush flags", {fl_done, fl_err}, 0);
        rst = 1'b0;
        @(negedge clk);

        // stream opening at lane 5, then a back-to-back store with a junk address
        do_store('h105, 1'b1, 1, "R2 R3", 1'b0, acc1);
        do_store('h7777, 1'b1, 2, "R6 R11", 1'b0, acc2);
        // R4: second store waits out the first store's beats
        chk(acc2 == acc1 + NB + 1, "R4", "second accept edge", acc2, acc1 + NB + 1);
        // R8: offset equals two post-updated vectors
        do_flush(2 * VB, "R8");

        // aligned stream leaves no tail
        do_store('h400, 1'b1, 3, "R2", 1'b0, acc1);
        do_flush(VB, "R10");

        // position ignores the no-post-update store, so 2*VB mismatches
        do_store('h81B, 1'b0, 4, "R7", 1'b0, acc1);
        do_store('h0, 1'b1, 5, "R7", 1'b0, acc1);
        do_flush(2 * VB, "R9 R7");

        // new stream: first block must not carry the discarded tail (R9)
        fl_valid = 1'b1;
        fl_off   = '0;
        do_store('h1003, 1'b0, 6, "R9 R3", 1'b1, acc1);
        fl_valid = 1'b0;
        chk(fl_done == 1'b0, "R12", "flush held behind store", fl_done, 0);
        do_flush(0, "R7 R8");

        repeat (NB + 4) @(negedge clk);
        // R5: every expected write was seen and nothing extra remains
        chk(q_addr.size() == 0, "R5", "writes left in scoreboard", q_addr.size(), 0);
        report();
    end

endmodule